// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog peripheral behind a simple register port. A down-counter, advanced by a slow tick enable (256 ticks per second in the intended system), counts from a programmed reload value towards zero. When it expires, the block raises a reset request or a fault interrupt and records the event in a status register. Software keeps the system alive by writing a restart command that carries a fixed key. That restart is accepted only inside a window near the end of the count, so a runaway loop that restarts too often is caught as well.

A timeout of N seconds is programmed as N*256-1, and 0 selects the shortest timeout. With the default 12-bit counter this covers 1 to 16 seconds. The mode register holds the reload and window fields, a disable bit, the expiry action and two freeze controls. While the block is disabled, the reload and window fields are locked. Two freeze inputs, one for idle and one for debug, halt the count when their mode bits allow it. The register port always accepts a write or read in the cycle it is presented, so it has no back-pressure. The outputs are plain level or pulse pins.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, status reads 0, both outputs are low, and mode reads back with the reload field (bits [11:0]) and the window field (bits [27:16]) all ones, the reset-enable bit 13 set, and the interrupt-enable bit 12, the disable bit 15, the idle-freeze bit 28 and the debug-freeze bit 29 clear. The counter starts at all ones.
- R2: The counter drops by one on each tick while the block runs. The tick that finds it at zero is an expiry: the counter reloads from the reload field and keeps running. So an expiry lands on tick reload+1 after a load.
- R3: While the disable bit is set, ticks leave the counter unchanged, restarts are ignored, and neither the reset request nor the interrupt asserts.
- R4: A mode write (address 1) that arrives while the block is disabled leaves the reload and window fields unchanged. Its other bits, including the disable bit itself, still take effect.
- R5: A control write (address 0) is a restart only when bits [31:24] equal 0xA5 and bit 0 is set. Any other control write has no effect.
- R6: A restart is accepted and reloads the counter when the current count is at most the window field. A restart with a higher count sets status bit 1, triggers the expiry action, and also reloads the counter.
- R7: With reset-enable set, an expiry or window error produces a reset-request pulse one clock long. With interrupt-enable set, the interrupt stays high for as long as any status flag is pending.
- R8: Status (address 2) holds bit 0 for an underflow expiry and bit 1 for a window error. A read of address 2 returns the flags and clears them.
- R9: The idle input freezes the counter only when mode bit 28 is set. The debug input freezes it only when mode bit 29 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow count enable, one cycle per tick |
| idle_in | input | 1 | System idle indication (freeze source) |
| debug_in | input | 1 | Debugger halt indication (freeze source) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mode |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; a status read clears the flags |
| rd_addr | input | 2 | Read address: 1 mode, 2 status |
| rd_data | output | 32 | Read data, valid in the same cycle as rd_en |
| rst_req | output | 1 | Reset request pulse |
| irq | output | 1 | Fault interrupt level |

## Verification
A wrong count or a wrong reload shows up as an expiry pulse on the wrong tick. For any reload value, the error is visible at the ports within reload+1 ticks. A wrong window compare shows up in the same cycle as the restart: either a reset pulse and status bit 1 appear where there should be none, or they are missing. Broken field locking, or a broken flag clear, shows up on the very next readback of mode or status. A freeze or disable that leaks shows up as a pulse during the frozen span.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W     = 32;
  localparam int FIELD_MAX = 12;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int B_IRQEN   = 12;
  localparam int B_RSTEN   = 13;
  localparam int B_DIS     = 15;
  localparam int DELTA_LSB = 16;
  localparam int B_IDLE    = 28;
  localparam int B_DBG     = 29;
  localparam int KEY_LSB   = 24;
  localparam logic [7:0] RESTART_KEY = 8'hA5;
  localparam int B_RESTART = 0;

  typedef struct packed {
    logic idle_halt;
    logic dbg_halt;
    logic dis;
    logic rst_en;
    logic irq_en;
  } mode_ctl_t;
endpackage

// File: rtl/wdog_mode.sv
module wdog_mode
  import wdog_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] delta,
  output mode_ctl_t        ctl,
  output logic [REG_W-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '1;
      delta  <= '1;
      ctl    <= '{idle_halt: 1'b0, dbg_halt: 1'b0, dis: 1'b0, rst_en: 1'b1, irq_en: 1'b0};
    end else if (wr) begin
      ctl.idle_halt <= wdata[B_IDLE];
      ctl.dbg_halt  <= wdata[B_DBG];
      ctl.dis       <= wdata[B_DIS];
      ctl.rst_en    <= wdata[B_RSTEN];
      ctl.irq_en    <= wdata[B_IRQEN];
      if (!ctl.dis) begin
        reload <= wdata[CNT_W-1:0];
        delta  <= wdata[DELTA_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CNT_W-1:0]          = reload;
    rdata[DELTA_LSB +: CNT_W] = delta;
    rdata[B_IRQEN]            = ctl.irq_en;
    rdata[B_RSTEN]            = ctl.rst_en;
    rdata[B_DIS]              = ctl.dis;
    rdata[B_IDLE]             = ctl.idle_halt;
    rdata[B_DBG]              = ctl.dbg_halt;
  end

  assert_fields_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctl.dis) |=> ($stable(reload) && $stable(delta)));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enabled,
  input  logic             frozen,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] delta,
  output logic             expire,
  output logic             win_err
);
  logic [CNT_W-1:0] count;
  logic             do_restart;
  logic             do_tick;

  assign do_restart = restart && enabled;
  assign do_tick    = tick && enabled && !frozen;
  assign win_err    = do_restart && (count > delta);
  assign expire     = !do_restart && do_tick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '1;
    end else if (do_restart) begin
      count <= reload;
    end else if (do_tick) begin
      if (count == '0) count <= reload;
      else             count <= count - 1'b1;
    end
  end

  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> $stable(count));
  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enabled && !frozen && !restart && count != '0)
      |=> (count == CNT_W'($past(count) - 1'b1)));
  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> $stable(count));
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       win_err,
  input  logic       rd_clr,
  input  logic       rst_en,
  input  logic       irq_en,
  input  logic       dis,
  output logic [1:0] flags,
  output logic       rst_req,
  output logic       irq
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      pulse_q <= 1'b0;
    end else begin
      flags   <= (rd_clr ? 2'b00 : flags) | {win_err, expire};
      pulse_q <= (expire || win_err) && rst_en;
    end
  end

  assign rst_req = pulse_q;
  assign irq     = irq_en && !dis && (flags != 2'b00);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !expire && !win_err) |=> (flags == 2'b00));
  assert_pulse_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(expire) || $past(win_err)));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        idle_in,
  input  logic        debug_in,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rst_req,
  output logic        irq
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] delta;
  mode_ctl_t        ctl;
  logic [REG_W-1:0] mode_rdata;
  logic [1:0]       flags;
  logic             mode_wr;
  logic             restart;
  logic             frozen;
  logic             expire;
  logic             win_err;
  logic             stat_rd;

  assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
  assign restart = wr_en && (wr_addr == ADDR_CTRL)
                && (wr_data[KEY_LSB +: 8] == RESTART_KEY) && wr_data[B_RESTART];
  assign frozen  = (idle_in && ctl.idle_halt) || (debug_in && ctl.dbg_halt);
  assign stat_rd = rd_en && (rd_addr == ADDR_STAT);

  wdog_mode #(.CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(wr_data),
    .reload(reload), .delta(delta), .ctl(ctl), .rdata(mode_rdata)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .enabled(!ctl.dis),
    .frozen(frozen), .restart(restart), .reload(reload), .delta(delta),
    .expire(expire), .win_err(win_err)
  );

  wdog_flags u_flags (
    .clk(clk), .rst_n(rst_n), .expire(expire), .win_err(win_err),
    .rd_clr(stat_rd), .rst_en(ctl.rst_en), .irq_en(ctl.irq_en), .dis(ctl.dis),
    .flags(flags), .rst_req(rst_req), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        ADDR_MODE: rd_data = mode_rdata;
        ADDR_STAT: rd_data = {30'd0, flags};
        default:   rd_data = '0;
      endcase
    end
  end

  assert_bad_key_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL && wr_data[KEY_LSB +: 8] != RESTART_KEY)
      |=> !$rose(flags[1]));
endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 4;
  localparam int FMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, idle_in = 1'b0, debug_in = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req, irq;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed #(.CNT_W(CW)) u_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idle_in(idle_in),
    .debug_in(debug_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .irq(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    cyc();
    tick_en = 1'b0;
  endtask

  function automatic logic [31:0] mode_word(input int rl, input int dl, input bit ie,
      input bit re, input bit ds, input bit ih, input bit dh);
    logic [31:0] m;
    m = '0;
    m[CW-1:0] = rl[CW-1:0];
    m[16 +: CW] = dl[CW-1:0];
    m[12] = ie; m[13] = re; m[15] = ds; m[28] = ih; m[29] = dh;
    return m;
  endfunction

  localparam logic [31:0] KICK = 32'hA500_0001;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired got %0d exp <150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit          e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(2'd1, v); check(v, mode_word(FMAX, FMAX, 0, 1, 0, 0, 0), "R1 mode after reset");
    rd(2'd2, v); check(v, 32'd0, "R1 status after reset");
    check({31'd0, rst_req}, 32'd0, "R1 rst_req after reset");
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    for (int t = 1; t <= FMAX + 1; t++) begin
      tick();
      check({31'd0, rst_req}, {31'd0, t == FMAX + 1}, "R1 initial count expiry");
    end
    cyc(); check({31'd0, rst_req}, 32'd0, "R7 pulse one cycle");
    rd(2'd2, v); check(v, 32'd1, "R8 underflow flag");
    rd(2'd2, v); check(v, 32'd0, "R8 cleared by read");

    // R2: expiry timing for every reload value, twice (reload and continue)
    for (int r = 0; r <= FMAX; r++) begin
      wr(2'd1, mode_word(r, FMAX, 0, 1, 0, 0, 0));
      wr(2'd0, KICK);
      for (int lap = 0; lap < 2; lap++) begin
        for (int t = 1; t <= r + 1; t++) begin
          tick();
          check({31'd0, rst_req}, {31'd0, t == r + 1}, "R2 expiry tick");
        end
      end
      rd(2'd2, v); check(v, 32'd1, "R8 status after expiry");
    end

    // R6: window sweep over delta and restart time
    for (int d = 0; d <= FMAX; d++) begin
      for (int k = 0; k <= FMAX; k++) begin
        wr(2'd1, mode_word(FMAX, FMAX, 0, 1, 0, 0, 0));
        wr(2'd0, KICK);
        wr(2'd1, mode_word(FMAX, d, 0, 1, 0, 0, 0));
        for (int t = 0; t < k; t++) tick();
        e = (FMAX - k) > d;
        wr(2'd0, KICK);
        check({31'd0, rst_req}, {31'd0, e}, "R6 window restart pulse");
        rd(2'd2, v); check(v, e ? 32'd2 : 32'd0, "R6 window error flag");
      end
    end

    // R5: wrong key and missing restart bit are ignored
    wr(2'd1, mode_word(FMAX, FMAX, 0, 1, 0, 0, 0));
    wr(2'd0, KICK);
    wr(2'd1, mode_word(FMAX, 0, 0, 1, 0, 0, 0));
    wr(2'd0, 32'h5A00_0001);
    check({31'd0, rst_req}, 32'd0, "R5 bad key no pulse");
    wr(2'd0, 32'hA500_0000);
    check({31'd0, rst_req}, 32'd0, "R5 no restart bit no pulse");
    rd(2'd2, v); check(v, 32'd0, "R5 status untouched");
    for (int t = 1; t <= FMAX + 1; t++) begin
      tick();
      check({31'd0, rst_req}, {31'd0, t == FMAX + 1}, "R5 count untouched");
    end
    rd(2'd2, v);

    // R3 / R4: disable holds counter and locks fields
    wr(2'd1, mode_word(3, FMAX, 1, 1, 0, 0, 0));
    wr(2'd0, KICK);
    wr(2'd1, mode_word(3, FMAX, 1, 1, 1, 0, 0));
    for (int t = 0; t < 20; t++) begin
      tick();
      check({30'd0, rst_req, irq}, 32'd0, "R3 outputs quiet while disabled");
    end
    wr(2'd0, KICK);
    wr(2'd1, mode_word(9, 9, 1, 1, 1, 0, 0));
    rd(2'd1, v); check(v, mode_word(3, FMAX, 1, 1, 1, 0, 0), "R4 fields locked");
    wr(2'd1, mode_word(7, 7, 1, 1, 0, 0, 0));
    rd(2'd1, v); check(v, mode_word(3, FMAX, 1, 1, 0, 0, 0), "R4 enabling write locked");
    for (int t = 1; t <= 4; t++) begin
      tick();
      check({31'd0, rst_req}, {31'd0, t == 4}, "R3 count held while disabled");
    end
    check({31'd0, irq}, 32'd1, "R7 irq with both actions");
    rd(2'd2, v); check(v, 32'd1, "R8 status both actions");
    wr(2'd1, mode_word(7, 7, 0, 1, 0, 0, 0));
    rd(2'd1, v); check(v, mode_word(7, 7, 0, 1, 0, 0, 0), "R4 write while enabled");

    // R9: freeze inputs
    wr(2'd1, mode_word(2, FMAX, 0, 1, 0, 1, 0));
    wr(2'd0, KICK);
    idle_in = 1'b1;
    for (int t = 0; t < 10; t++) begin
      tick(); check({31'd0, rst_req}, 32'd0, "R9 idle freeze");
    end
    idle_in = 1'b0; debug_in = 1'b1;
    for (int t = 1; t <= 3; t++) begin
      tick(); check({31'd0, rst_req}, {31'd0, t == 3}, "R9 debug without bit runs");
    end
    rd(2'd2, v);
    wr(2'd1, mode_word(2, FMAX, 0, 1, 0, 0, 1));
    wr(2'd0, KICK);
    for (int t = 0; t < 10; t++) begin
      tick(); check({31'd0, rst_req}, 32'd0, "R9 debug freeze");
    end
    debug_in = 1'b0;
    for (int t = 1; t <= 3; t++) begin
      tick(); check({31'd0, rst_req}, {31'd0, t == 3}, "R9 after debug release");
    end
    rd(2'd2, v);

    // R7: interrupt only
    wr(2'd1, mode_word(1, FMAX, 1, 0, 0, 0, 0));
    wr(2'd0, KICK);
    tick(); check({30'd0, rst_req, irq}, 32'd0, "R7 before expiry");
    tick(); check({30'd0, rst_req, irq}, 32'd1, "R7 irq no reset");
    cyc();  check({31'd0, irq}, 32'd1, "R7 irq level held");
    rd(2'd2, v); check(v, 32'd1, "R8 irq status");
    check({31'd0, irq}, 32'd0, "R7 irq cleared by status read");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule